// File: doc/BRIEF.md
# Two-Bank SDRAM Command Controller

This block sits between a simple host port and a 16-bit synchronous DRAM with two independent banks. The host presents one word-sized read or write at a time, with a bank, row and column, a two-bit byte mask and a per-access auto-precharge choice. The controller converts each request into chip-select, row-strobe, column-strobe and write-enable commands and drives the shared address bus. It remembers which row is open in each bank, so an access to an already open row goes straight to the column command. An access to a closed bank activates the row first, and an access to a different row precharges the old one first.

After reset the controller closes both banks, issues two refreshes and loads the mode register with a one-word burst and the CAS latency picked by `cas_lat3`. Only then does it accept host requests. A free-running interval timer raises a refresh request. The pending refresh beats new host requests: open rows are closed with a precharge-all and an auto-refresh follows. Read data returns on `host_rvalid` a fixed number of cycles after the read command, and that delay follows the latched CAS latency.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held the command is NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), with no ack, no read valid and no data drive. After reset the first four commands are precharge-all (0010 with `sd_addr[10]`=1), refresh (0001), refresh, and mode load (0000). Consecutive commands are at least T_RP, T_RFC and T_RFC cycles apart, and no host request is acknowledged before the mode load.
- R2: The mode-load address holds 0 in bits [3:0] (one-word burst, sequential order) and the CAS latency in bits [6:4] (2 when `cas_lat3`=0, 3 when it is 1). All other bits are 0.
- R3: An access to a closed bank issues activate (0011) with the row on `sd_addr[10:0]` and the bank on `sd_addr[11]`. The read (0101) or write (0100) follows exactly T_RCD cycles later, and no read or write is ever issued to a bank without an open row.
- R4: A read or write carries the column on `sd_addr[7:0]`, the auto-precharge choice on `sd_addr[10]` and the bank on `sd_addr[11]`. `host_ack` is high in exactly the cycles in which a read or write command is on the bus.
- R5: An access to the row already open in its bank issues the read or write with no activate or precharge before it.
- R6: An access to an open bank with a different row issues a single-bank precharge (0010, `sd_addr[10]`=0, bank on bit 11), then activate T_RP cycles later. Activate is never issued to a bank that is already open.
- R7: Opening a row in one bank leaves the open row of the other bank intact, so returning to that row is a hit.
- R8: An access with `host_autopre`=1 leaves its bank closed, so the next access to that bank starts with activate.
- R9: `host_rvalid` pulses CL+1 cycles after the read command cycle and carries the word the device drove CL cycles after sampling the read. Each read gives exactly one pulse, in issue order.
- R10: During a write, `sd_dq_oe`=1, `sd_dq_out` holds the host word and `sd_dqm` holds the host mask (bit 1 masks the upper byte, bit 0 the lower, 1 = masked). Outside writes, `sd_dq_oe` and `sd_dqm` are 0.
- R11: Every REFI cycles a refresh becomes pending. Open rows are closed by a precharge-all at least T_RP before the refresh, no refresh is issued while any bank is open, and after refresh every access starts with activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat3 | input | 1 | CAS latency choice loaded at init: 0 = 2, 1 = 3 |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bank | input | 1 | Target bank |
| host_row | input | 11 | Target row |
| host_col | input | 8 | Target column |
| host_autopre | input | 1 | Close the row after this access |
| host_wdata | input | 16 | Write word |
| host_wmask | input | 2 | Byte mask for the write, 1 = keep old byte |
| host_ack | output | 1 | Request accepted; column command issued this cycle |
| host_rdata | output | 16 | Returned read word |
| host_rvalid | output | 1 | host_rdata valid |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Row/column/mode address; bit 11 bank, bit 10 precharge-all or auto-precharge |
| sd_dqm | output | 2 | Byte masks to the device |
| sd_dq_out | output | 16 | Write data to the device |
| sd_dq_oe | output | 1 | Drive enable for write data |
| sd_dq_in | input | 16 | Read data from the device |

## Verification
On every cycle the assertions check the command legality that follows from a shadow of bank state rebuilt from the command bus. No column command goes to a closed bank, no activate goes to an open one, no refresh happens while a row is open, and nothing is acknowledged before the mode load. They also tie ack, data drive and masks to column and write commands, and tie each read-valid pulse to a read exactly CL+1 cycles earlier. The bench scenarios show what only a stimulus sequence reveals. These are the exact init order and mode word at both latencies, hit, miss and conflict sequences with their cycle spacing, byte-masked merges seen through read-back, auto-precharge forcing a new activate, and periodic refresh spacing with rows closed afterwards.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row
);
    logic             open_d, open_q;
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        open_d = open_q;
        row_d  = row_q;
        if (close) begin
            open_d = 1'b0;
        end else if (open_set) begin
            open_d = 1'b1;
            row_d  = row_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else begin
            open_q <= open_d;
            row_q  <= row_d;
        end
    end

    assign is_open = open_q;
    assign row     = row_q;
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int REFI = 1300
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(REFI);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == '0) cnt_d = CNT_W'(REFI - 1);
        else             cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_W'(REFI - 1);
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
    parameter int DATA_W = 16,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              cl3,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    localparam int PIPE_W = MAX_CL + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;
    logic              vld_d, vld_q;
    logic [DATA_W-1:0] dat_d, dat_q;
    logic              tap;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], issue};
        tap    = cl3 ? pipe_q[3] : pipe_q[2];
        vld_d  = tap;
        dat_d  = tap ? dq_in : dat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            vld_q  <= 1'b0;
            dat_q  <= '0;
        end else begin
            pipe_q <= pipe_d;
            vld_q  <= vld_d;
            dat_q  <= dat_d;
        end
    end

    assign rvalid = vld_q;
    assign rdata  = dat_q;
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 1,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 2,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 7,
    parameter int T_MRD  = 2,
    parameter int REFI   = 1300
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cas_lat3,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [BANK_W-1:0]       host_bank,
    input  logic [ROW_W-1:0]        host_row,
    input  logic [COL_W-1:0]        host_col,
    input  logic                    host_autopre,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic [DATA_W/8-1:0]     host_wmask,
    output logic                    host_ack,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    host_rvalid,
    output logic                    sd_cs_n,
    output logic                    sd_ras_n,
    output logic                    sd_cas_n,
    output logic                    sd_we_n,
    output logic [ROW_W+BANK_W-1:0] sd_addr,
    output logic [DATA_W/8-1:0]     sd_dqm,
    output logic [DATA_W-1:0]       sd_dq_out,
    output logic                    sd_dq_oe,
    input  logic [DATA_W-1:0]       sd_dq_in
);
    localparam int ADDR_W = ROW_W + BANK_W;
    localparam int NB     = 1 << BANK_W;
    localparam int MASK_W = DATA_W / 8;
    localparam int AP_BIT = 10;
    localparam int TM_A   = (T_RFC > T_RP)  ? T_RFC : T_RP;
    localparam int TM_B   = (T_RCD > T_MRD) ? T_RCD : T_MRD;
    localparam int TMAX   = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int TIM_W  = $clog2(TMAX + 2);

    typedef struct packed {
        ctl_state_e        state;
        logic [2:0]        step;
        logic [TIM_W-1:0]  timer;
        logic              ref_pend;
        logic              cl3;
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] dqm;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic              ack;
    } ctl_t;

    ctl_t n_d, c_q;

    logic [NB-1:0]    bank_open;
    logic [ROW_W-1:0] bank_row [NB];
    logic [NB-1:0]    bk_act, bk_close;
    logic             rd_issue;
    logic             ref_tick;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_track #(.ROW_W(ROW_W)) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_set (bk_act[b]),
            .close    (bk_close[b]),
            .row_in   (host_row),
            .is_open  (bank_open[b]),
            .row      (bank_row[b])
        );
    end

    sdram_ref_timer #(.REFI(REFI)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick)
    );

    sdram_rd_pipe #(.DATA_W(DATA_W)) u_rdp (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (rd_issue),
        .cl3    (c_q.cl3),
        .dq_in  (sd_dq_in),
        .rvalid (host_rvalid),
        .rdata  (host_rdata)
    );

    always_comb begin
        n_d      = c_q;
        n_d.cmd  = CMD_NOP;
        n_d.addr = '0;
        n_d.dqm  = '0;
        n_d.dq   = '0;
        n_d.oe   = 1'b0;
        n_d.ack  = 1'b0;
        bk_act   = '0;
        bk_close = '0;
        rd_issue = 1'b0;
        if (ref_tick) n_d.ref_pend = 1'b1;

        if (c_q.timer != '0) begin
            n_d.timer = c_q.timer - 1'b1;
        end else if (c_q.state == ST_INIT) begin
            case (c_q.step)
                3'd0: begin
                    n_d.cmd          = CMD_PRE;
                    n_d.addr[AP_BIT] = 1'b1;
                    bk_close         = '1;
                    n_d.timer        = TIM_W'(T_RP - 1);
                    n_d.step         = 3'd1;
                end
                3'd1, 3'd2: begin
                    n_d.cmd   = CMD_REF;
                    n_d.timer = TIM_W'(T_RFC - 1);
                    n_d.step  = c_q.step + 3'd1;
                end
                default: begin
                    n_d.cmd       = CMD_MRS;
                    n_d.addr[6:4] = cas_lat3 ? 3'd3 : 3'd2;
                    n_d.cl3       = cas_lat3;
                    n_d.timer     = TIM_W'(T_MRD - 1);
                    n_d.state     = ST_RUN;
                end
            endcase
        end else if (c_q.ref_pend) begin
            if (|bank_open) begin
                n_d.cmd          = CMD_PRE;
                n_d.addr[AP_BIT] = 1'b1;
                bk_close         = '1;
                n_d.timer        = TIM_W'(T_RP - 1);
            end else begin
                n_d.cmd      = CMD_REF;
                n_d.ref_pend = ref_tick;
                n_d.timer    = TIM_W'(T_RFC - 1);
            end
        end else if (host_req) begin
            n_d.addr[ROW_W +: BANK_W] = host_bank;
            if (bank_open[host_bank] && bank_row[host_bank] == host_row) begin
                n_d.cmd               = host_we ? CMD_WR : CMD_RD;
                n_d.addr[COL_W-1:0]   = host_col;
                n_d.addr[AP_BIT]      = host_autopre;
                n_d.ack               = 1'b1;
                if (host_we) begin
                    n_d.dq  = host_wdata;
                    n_d.oe  = 1'b1;
                    n_d.dqm = host_wmask;
                end else begin
                    rd_issue = 1'b1;
                end
                if (host_autopre) begin
                    bk_close[host_bank] = 1'b1;
                    n_d.timer           = TIM_W'(T_RP);
                end
            end else if (bank_open[host_bank]) begin
                n_d.cmd             = CMD_PRE;
                bk_close[host_bank] = 1'b1;
                n_d.timer           = TIM_W'(T_RP - 1);
            end else begin
                n_d.cmd               = CMD_ACT;
                n_d.addr[ROW_W-1:0]   = host_row;
                bk_act[host_bank]     = 1'b1;
                n_d.timer             = TIM_W'(T_RCD - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_INIT;
            c_q.cmd   <= CMD_NOP;
        end else begin
            c_q <= n_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = c_q.cmd;
    assign sd_addr   = c_q.addr;
    assign sd_dqm    = c_q.dqm;
    assign sd_dq_out = c_q.dq;
    assign sd_dq_oe  = c_q.oe;
    assign host_ack  = c_q.ack;
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
    parameter int ROW_W  = 11,
    parameter int BANK_W = 1,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cas_lat3,
    input logic                    host_ack,
    input logic                    host_rvalid,
    input logic                    sd_cs_n,
    input logic                    sd_ras_n,
    input logic                    sd_cas_n,
    input logic                    sd_we_n,
    input logic [ROW_W+BANK_W-1:0] sd_addr,
    input logic [DATA_W/8-1:0]     sd_dqm,
    input logic                    sd_dq_oe
);
    localparam int NB = 1 << BANK_W;
    localparam logic [3:0] K_MRS = 4'b0000, K_REF = 4'b0001, K_PRE = 4'b0010,
                           K_ACT = 4'b0011, K_WR  = 4'b0100, K_RD  = 4'b0101,
                           K_NOP = 4'b0111;

    logic [3:0]        cmd;
    logic [BANK_W-1:0] bk;
    logic [NB-1:0]     shadow_q;
    logic              mrs_seen_q;
    logic              is_col;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign bk     = sd_addr[ROW_W +: BANK_W];
    assign is_col = (cmd == K_RD) || (cmd == K_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q   <= '0;
            mrs_seen_q <= 1'b0;
        end else begin
            if (cmd == K_MRS) mrs_seen_q <= 1'b1;
            if (cmd == K_ACT) shadow_q[bk] <= 1'b1;
            if (cmd == K_PRE && sd_addr[10]) shadow_q <= '0;
            if (cmd == K_PRE && !sd_addr[10]) shadow_q[bk] <= 1'b0;
            if (is_col && sd_addr[10]) shadow_q[bk] <= 1'b0;
        end
    end

    a_r1_no_ack_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> mrs_seen_q);
    a_r4_ack_means_column: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> is_col);
    a_r4_column_means_ack: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> host_ack);
    a_r3_column_to_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> shadow_q[bk]);
    a_r6_activate_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == K_ACT) |-> !shadow_q[bk]);
    a_r11_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == K_REF) |-> (shadow_q == '0));
    a_r10_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == K_WR));
    a_r10_mask_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_dqm != '0) |-> (cmd == K_WR));
    a_r9_valid_after_cl2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && !cas_lat3) |-> ($past(cmd, 3) == K_RD));
    a_r9_valid_after_cl3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && cas_lat3) |-> ($past(cmd, 4) == K_RD));

    if (T_RCD > 1) begin : g_rcd
        a_r3_gap_after_activate: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == K_ACT) |=> (cmd == K_NOP));
    end
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .DATA_W(DATA_W),
    .T_RCD (T_RCD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cas_lat3   (cas_lat3),
    .host_ack   (host_ack),
    .host_rvalid(host_rvalid),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .sd_dqm     (sd_dqm),
    .sd_dq_oe   (sd_dq_oe)
);

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;
    localparam int T_RCD = 2, T_RP = 2, T_RFC = 7, T_MRD = 2, REFI = 1300;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [11:0] addr;
        logic [1:0]  dqm;
        logic [15:0] dq;
        logic        oe;
    } tr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, cas_lat3 = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_bank = 1'b0, host_autopre = 1'b0;
    logic [10:0] host_row = '0;
    logic [7:0]  host_col = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_wmask = '0;
    logic        host_ack, host_rvalid;
    logic [15:0] host_rdata;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = '0;

    always #2 clk = ~clk;

    sdram_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
        .host_req(host_req), .host_we(host_we), .host_bank(host_bank),
        .host_row(host_row), .host_col(host_col), .host_autopre(host_autopre),
        .host_wdata(host_wdata), .host_wmask(host_wmask),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int          cyc = 0, n_chk = 0, n_fail = 0, cl = 2;
    tr_t         tr[$];
    logic [15:0] mem [int];
    logic [15:0] refm [int];
    logic [10:0] mrow [2];
    logic [16:0] rd_sh [4];
    logic [15:0] exp_q[$];
    int          expc_q[$];
    logic [3:0]  cmdv;
    logic [15:0] wv, ev;
    int          key, ec;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // device model and scoreboard monitor, sampled 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) rd_sh[k] = '0;
        end else begin
            cmdv = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            for (int k = 3; k > 0; k--) rd_sh[k] = rd_sh[k-1];
            rd_sh[0] = '0;
            if (cmdv != C_NOP) tr.push_back('{cyc, cmdv, sd_addr, sd_dqm, sd_dq_out, sd_dq_oe});
            key = int'({sd_addr[11], mrow[sd_addr[11]], sd_addr[7:0]});
            if (cmdv == C_ACT) mrow[sd_addr[11]] = sd_addr[10:0];
            if (cmdv == C_WR) begin
                wv = mem.exists(key) ? mem[key] : 16'h0;
                if (!sd_dqm[0]) wv[7:0]  = sd_dq_out[7:0];
                if (!sd_dqm[1]) wv[15:8] = sd_dq_out[15:8];
                mem[key] = wv;
            end
            if (cmdv == C_RD) rd_sh[0] = {1'b1, mem.exists(key) ? mem[key] : 16'h0};
            sd_dq_in = rd_sh[cl][15:0];
            if (host_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected read valid", host_rdata, 0);
                end else begin
                    ev = exp_q.pop_front();
                    ec = expc_q.pop_front();
                    check(host_rdata == ev, "R9 read data", host_rdata, ev);
                    check(cyc == ec + cl + 1, "R9 read latency", cyc - ec, cl + 1);
                end
            end
        end
    end

    task automatic access(input bit we, input bit bank, input int row, input int col,
                          input bit ap, input logic [15:0] d, input logic [1:0] m,
                          output int idx);
        int k;
        logic [15:0] v;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_bank = bank; host_row = 11'(row);
        host_col = 8'(col); host_autopre = ap; host_wdata = d; host_wmask = m;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
        idx = tr.size() - 1;
        k = int'({bank, 11'(row), 8'(col)});
        if (we) begin
            v = refm.exists(k) ? refm[k] : 16'h0;
            if (!m[0]) v[7:0]  = d[7:0];
            if (!m[1]) v[15:8] = d[15:8];
            refm[k] = v;
        end else begin
            exp_q.push_back(refm.exists(k) ? refm[k] : 16'h0);
            expc_q.push_back(tr[idx].cyc);
        end
    endtask

    task automatic wait_ref(input int from, output int idx);
        idx = -1;
        while (idx < 0) begin
            @(negedge clk);
            for (int k = from; k < tr.size(); k++)
                if (idx < 0 && tr[k].cmd == C_REF) idx = k;
        end
    endtask

    task automatic do_reset(input bit c3);
        logic [11:0] mode;
        @(negedge clk);
        rst_n = 1'b0; cas_lat3 = c3; cl = c3 ? 3 : 2; host_req = 1'b0;
        repeat (4) @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset command",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(!host_ack && !host_rvalid && !sd_dq_oe, "R1 reset outputs",
              {host_ack, host_rvalid, sd_dq_oe}, 0);
        tr.delete(); exp_q.delete(); expc_q.delete(); mem.delete(); refm.delete();
        rst_n = 1'b1;
        while (tr.size() < 4) @(negedge clk);
        repeat (T_MRD + 2) @(negedge clk);
        check(tr.size() == 4, "R1 nothing before host", tr.size(), 4);
        check(tr[0].cmd == C_PRE && tr[0].addr[10], "R1 first precharge-all",
              {tr[0].cmd, tr[0].addr}, {C_PRE, 12'h400});
        check(tr[1].cmd == C_REF && tr[2].cmd == C_REF, "R1 two refreshes",
              {tr[1].cmd, tr[2].cmd}, {C_REF, C_REF});
        check(tr[1].cyc - tr[0].cyc >= T_RP, "R1 precharge gap", tr[1].cyc - tr[0].cyc, T_RP);
        check(tr[2].cyc - tr[1].cyc >= T_RFC, "R1 refresh gap", tr[2].cyc - tr[1].cyc, T_RFC);
        check(tr[3].cyc - tr[2].cyc >= T_RFC, "R1 refresh gap 2", tr[3].cyc - tr[2].cyc, T_RFC);
        mode = c3 ? 12'h030 : 12'h020;
        check(tr[3].cmd == C_MRS && tr[3].addr == mode, "R2 mode word",
              {tr[3].cmd, tr[3].addr}, {C_MRS, mode});
    endtask

    initial begin : main
        int i, j, j2;
        do_reset(1'b0);

        // closed bank: activate, T_RCD, write
        access(1'b1, 1'b0, 5, 3, 1'b0, 16'hA5A5, 2'b00, i);
        check(tr[i].cmd == C_WR && tr[i].addr == 12'h003, "R4 write column/bank/ap",
              {tr[i].cmd, tr[i].addr}, {C_WR, 12'h003});
        check(tr[i].oe && tr[i].dq == 16'hA5A5 && tr[i].dqm == 2'b00, "R10 write data",
              tr[i].dq, 16'hA5A5);
        check(tr[i-1].cmd == C_ACT && tr[i-1].addr == 12'h005, "R3 activate row",
              {tr[i-1].cmd, tr[i-1].addr}, {C_ACT, 12'h005});
        check(tr[i].cyc - tr[i-1].cyc == T_RCD, "R3 activate-to-column", tr[i].cyc - tr[i-1].cyc, T_RCD);

        // row hit read
        access(1'b0, 1'b0, 5, 3, 1'b0, 16'h0, 2'b00, i);
        check(tr[i].cmd == C_RD && tr[i-1].cmd == C_WR, "R5 hit without activate",
              tr[i-1].cmd, C_WR);

        // masked write keeps upper byte
        access(1'b1, 1'b0, 5, 3, 1'b0, 16'h1234, 2'b10, i);
        check(tr[i].dqm == 2'b10, "R10 mask applied", tr[i].dqm, 2'b10);
        access(1'b0, 1'b0, 5, 3, 1'b0, 16'h0, 2'b00, i);

        // other bank, then back to bank 0 row 5
        access(1'b1, 1'b1, 7, 8, 1'b0, 16'hBEEF, 2'b00, i);
        check(tr[i-1].cmd == C_ACT && tr[i-1].addr == 12'h807, "R7 bank 1 activate",
              {tr[i-1].cmd, tr[i-1].addr}, {C_ACT, 12'h807});
        access(1'b0, 1'b0, 5, 3, 1'b0, 16'h0, 2'b00, i);
        check(tr[i-1].cmd == C_WR, "R7 bank 0 still open", tr[i-1].cmd, C_WR);

        // row conflict in bank 0
        access(1'b1, 1'b0, 9, 1, 1'b0, 16'h0F0F, 2'b00, i);
        check(tr[i-2].cmd == C_PRE && tr[i-2].addr == 12'h000, "R6 single-bank precharge",
              {tr[i-2].cmd, tr[i-2].addr}, {C_PRE, 12'h000});
        check(tr[i-1].cmd == C_ACT && tr[i-1].addr == 12'h009, "R6 new row activate",
              {tr[i-1].cmd, tr[i-1].addr}, {C_ACT, 12'h009});
        check(tr[i-1].cyc - tr[i-2].cyc == T_RP, "R6 precharge-to-activate",
              tr[i-1].cyc - tr[i-2].cyc, T_RP);

        // auto-precharge closes bank 1
        access(1'b1, 1'b1, 7, 8, 1'b1, 16'h5555, 2'b00, i);
        check(tr[i].addr == 12'hC08, "R8 auto-precharge flag", tr[i].addr, 12'hC08);
        access(1'b0, 1'b1, 7, 8, 1'b0, 16'h0, 2'b00, i);
        check(tr[i-1].cmd == C_ACT && tr[i-1].addr == 12'h807, "R8 reopen after auto-precharge",
              {tr[i-1].cmd, tr[i-1].addr}, {C_ACT, 12'h807});
        access(1'b0, 1'b0, 9, 1, 1'b0, 16'h0, 2'b00, i);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);

        // periodic refresh with both banks open
        wait_ref(4, j);
        check(tr[j-1].cmd == C_PRE && tr[j-1].addr[10], "R11 precharge-all before refresh",
              {tr[j-1].cmd, tr[j-1].addr}, {C_PRE, 12'h400});
        check(tr[j].cyc - tr[j-1].cyc >= T_RP, "R11 precharge gap", tr[j].cyc - tr[j-1].cyc, T_RP);
        wait_ref(j + 1, j2);
        check(tr[j2].cyc - tr[j].cyc >= REFI - T_RP && tr[j2].cyc - tr[j].cyc <= REFI,
              "R11 refresh interval", tr[j2].cyc - tr[j].cyc, REFI - T_RP);
        access(1'b0, 1'b0, 9, 1, 1'b0, 16'h0, 2'b00, i);
        check(tr[i-1].cmd == C_ACT && tr[i-1].addr == 12'h009, "R11 rows closed after refresh",
              {tr[i-1].cmd, tr[i-1].addr}, {C_ACT, 12'h009});
        repeat (8) @(negedge clk);

        // CAS latency 3
        do_reset(1'b1);
        access(1'b1, 1'b1, 2, 4, 1'b0, 16'hC3C3, 2'b01, i);
        access(1'b0, 1'b1, 2, 4, 1'b0, 16'h0, 2'b00, i);
        access(1'b1, 1'b1, 2, 5, 1'b0, 16'h7E81, 2'b00, i);
        access(1'b0, 1'b1, 2, 5, 1'b1, 16'h0, 2'b00, i);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads returned at CL3", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule